// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block is a small I/O-mapped register set for a system power-management controller. It holds a status word with four event flags, an enable word, a control word and a free-running power-management counter. It raises a level interrupt toward the system whenever an event flag is set and the matching enable bit is set. Software finds the block through a base address taken from a configuration dword. The window decodes only while a configuration enable bit is set.

Event pulses from the power button, the real-time-clock alarm and the global-lock release set their flags. A tick-enable input advances the counter. The counter's wrap sets the fourth flag. Software reads the flags, clears them by writing ones, and programs the enable word to choose which flags interrupt. Accesses are either 16 or 32 bits wide, and the width selects which registers respond.

Top module: `pm_evt_regs`

## Requirements
- R1: After reset the status, enable and control words and the counter are all 0, and `sci` is low.
- R2: An access hits only when `win_en` is 1 and `io_addr` ANDed with 0xFFC0 equals `cfg_base[15:0]` ANDed with 0xFFC0. Missed writes change nothing, and missed reads return 0.
- R3: Inside the 64-byte window only address bits 3:0 select a register, so offset 0x10 aliases offset 0x0 and 0x12 aliases 0x2.
- R4: A 16-bit access (`io_wide`=0) uses offset 0x0 for status, 0x2 for enable and 0x4 for control. Its data sits in bits 15:0. A 16-bit read of any other offset returns 0.
- R5: A 32-bit read (`io_wide`=1) at offset 0x8 returns the counter, zero-extended. Every other 32-bit read returns 0, and every 32-bit write is ignored.
- R6: Status flags sit at bit 0 (counter wrap), bit 5 (global lock), bit 8 (power button) and bit 10 (RTC alarm). All other status bits read 0. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R7: An event input high on a clock edge sets its flag. In the cycle of a clearing write, the clear wins. An event input that stays high sets the flag again one cycle later.
- R8: The counter has TMR_W bits (24 by default) and adds 1 on each edge where `tmr_tick` is 1. When it wraps from all ones to 0, it sets status bit 0.
- R9: `sci` is high exactly when status AND enable has any of bits 0, 5, 8 or 10 set. Other enable bits have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configuration dword holding the window base |
| win_en | input | 1 | Window enable from configuration space |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, 0 when no register is selected |
| evt_pwrbtn | input | 1 | Power button event |
| evt_rtc | input | 1 | RTC alarm event |
| evt_glbl | input | 1 | Global lock release event |
| tmr_tick | input | 1 | Counter advance enable |
| sci | output | 1 | Level interrupt output |

## Verification
The assertions check four things on every cycle. Cleared flags stay clear on the edge after a clearing write. The counter steps by exactly one per tick and holds without one. Missed writes and 32-bit writes leave the enable and control words alone. `sci` rises only after an enable write or an event.

Some behaviour depends on sequences and data values, so only the bench's scenarios can show it. These cover the register map and aliasing seen through reads, the zero returns, the one-cycle gap before a held event sets its flag again, the counter wrap setting its flag, and the masking of non-event enable bits.

// File: rtl/pm_evt_regs.sv
module pm_evt_regs #(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_base,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_wide,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic              evt_pwrbtn,
  input  logic              evt_rtc,
  input  logic              evt_glbl,
  input  logic              tmr_tick,
  output logic              sci
);
  localparam logic [15:0]       FLAG_MASK = 16'h0521;
  localparam logic [ADDR_W-1:0] WIN_MASK  = {{(ADDR_W-6){1'b1}}, 6'b0};

  logic [15:0]      sts_q, en_q, cnt_q;
  logic [TMR_W-1:0] tmr_q;

  wire hit    = win_en && ((io_addr & WIN_MASK) == (cfg_base[ADDR_W-1:0] & WIN_MASK));
  wire [3:0] off = io_addr[3:0];
  wire wr16   = hit && io_wr && !io_wide;
  wire wr_sts = wr16 && (off == 4'h0);
  wire wr_en  = wr16 && (off == 4'h2);
  wire wr_cnt = wr16 && (off == 4'h4);

  wire tmr_carry = tmr_tick && (&tmr_q);
  wire [15:0] ev_set = (16'(evt_rtc) << 10) | (16'(evt_pwrbtn) << 8) |
                       (16'(evt_glbl) << 5) | 16'(tmr_carry);
  wire [15:0] clr = wr_sts ? (io_wdata[15:0] & FLAG_MASK) : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      sts_q <= (sts_q | ev_set) & ~clr;
      if (wr_en)    en_q  <= io_wdata[15:0];
      if (wr_cnt)   cnt_q <= io_wdata[15:0];
      if (tmr_tick) tmr_q <= tmr_q + 1'b1;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (hit && io_rd) begin
      if (!io_wide) begin
        case (off)
          4'h0:    io_rdata[15:0] = sts_q;
          4'h2:    io_rdata[15:0] = en_q;
          4'h4:    io_rdata[15:0] = cnt_q;
          default: io_rdata = '0;
        endcase
      end else if (off == 4'h8) begin
        io_rdata[TMR_W-1:0] = tmr_q;
      end
    end
  end

  assign sci = |(sts_q & en_q & FLAG_MASK);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (sts_q == 16'h0 && en_q == 16'h0 && !sci));

  assert_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !hit) |=> ($stable(en_q) && $stable(cnt_q)));

  assert_wide_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_wide) |=> ($stable(en_q) && $stable(cnt_q)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((sts_q & $past(io_wdata[15:0]) & FLAG_MASK) == 16'h0));

  assert_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pwrbtn && !clr[8]) |=> sts_q[8]);

  assert_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> (tmr_q == $past(tmr_q) + 1'b1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_tick |=> $stable(tmr_q));

  assert_sci_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> ($past(wr_en) || $past(ev_set != 16'h0)));
endmodule

// File: tb/pm_evt_regs_tb.sv
module pm_evt_regs_tb;
  localparam int TW = 10;
  localparam logic [15:0] MASK = 16'h0521;
  localparam logic [15:0] B = 16'hB080;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_base = 32'h0000_B0A7;
  logic win_en = 1;
  logic [15:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0, io_wide = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic evt_pwrbtn = 0, evt_rtc = 0, evt_glbl = 0, tmr_tick = 0;
  logic sci;

  int checks = 0, fails = 0;
  logic [15:0] e_sts = 0, e_en = 0, e_cnt = 0;

  always #10 clk = ~clk;

  pm_evt_regs #(.ADDR_W(16), .TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .win_en(win_en),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .evt_pwrbtn(evt_pwrbtn),
    .evt_rtc(evt_rtc), .evt_glbl(evt_glbl), .tmr_tick(tmr_tick), .sci(sci));

  function automatic logic [15:0] ev_bits(logic g, logic p, logic r);
    return (16'(r) << 10) | (16'(p) << 8) | (16'(g) << 5);
  endfunction

  function automatic logic exp_sci(logic [15:0] s, logic [15:0] e);
    return |(s & e & MASK);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [31:0] d, logic w32);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wide = w32; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic w32, output logic [31:0] v);
    @(negedge clk);
    io_addr = a; io_wide = w32; io_rd = 1;
    #2 v = io_rdata;
    io_rd = 0;
  endtask

  task automatic pulse(logic g, logic p, logic r);
    @(negedge clk);
    evt_glbl = g; evt_pwrbtn = p; evt_rtc = r;
    @(negedge clk);
    evt_glbl = 0; evt_pwrbtn = 0; evt_rtc = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    #35 rst_n = 1;

    // R1 reset state
    bus_rd(B + 0, 0, v); check("R1 sts", v, 0);
    bus_rd(B + 2, 0, v); check("R1 en", v, 0);
    bus_rd(B + 8, 1, v); check("R1 tmr", v, 0);
    check("R1 sci", sci, 0);

    // R4 register map
    bus_wr(B + 2, 32'h1234_0521, 0); e_en = 16'h0521;
    bus_wr(B + 4, 32'h0000_5A5A, 0); e_cnt = 16'h5A5A;
    bus_rd(B + 2, 0, v); check("R4 en", v, 32'h0521);
    bus_rd(B + 4, 0, v); check("R4 cnt", v, 32'h5A5A);
    bus_rd(B + 6, 0, v); check("R4 other", v, 0);
    bus_rd(B + 8, 0, v); check("R4 off8 16bit", v, 0);

    // R3 aliasing
    bus_wr(B + 16'h12, 32'h0000_0100, 0); e_en = 16'h0100;
    bus_rd(B + 16'h22, 0, v); check("R3 alias", v, 32'h0100);

    // R2 out of window and disabled
    bus_wr(B + 16'h42, 32'hFFFF, 0);
    bus_rd(B + 16'h42, 0, v); check("R2 miss rd", v, 0);
    bus_rd(B + 2, 0, v); check("R2 miss wr", v, {16'h0, e_en});
    win_en = 0;
    bus_wr(B + 2, 32'hFFFF, 0);
    bus_rd(B + 2, 0, v); check("R2 disabled rd", v, 0);
    win_en = 1;
    bus_rd(B + 2, 0, v); check("R2 disabled wr", v, {16'h0, e_en});

    // R5 wide access
    bus_wr(B + 2, 32'hFFFF_FFFF, 1);
    bus_rd(B + 2, 0, v); check("R5 wide wr ignored", v, {16'h0, e_en});
    bus_rd(B + 0, 1, v); check("R5 wide rd other", v, 0);

    // R6/R7/R9 event, W1C, sci masking
    pulse(0, 1, 0); e_sts = 16'h0100;
    #2 check("R9 sci set", sci, 1);
    bus_rd(B + 0, 0, v); check("R7 pwr flag", v, 32'h0100);
    bus_wr(B + 0, 32'hFEFF, 0);
    bus_rd(B + 0, 0, v); check("R6 write0 keeps", v, 32'h0100);
    bus_wr(B + 0, 32'h0100, 0); e_sts = 0;
    #2 check("R6 w1c sci", sci, 0);
    bus_wr(B + 2, 32'hFADE, 0); e_en = 16'hFADE;
    pulse(1, 1, 1); e_sts = 16'h0520;
    bus_rd(B + 0, 0, v); check("R6 positions", v, 32'h0520);
    #2 check("R9 non-event enables", sci, 0);
    bus_wr(B + 0, 32'hFFFF, 0); e_sts = 0;

    // R7 held event: clear wins, then sets again
    bus_wr(B + 2, 32'h0100, 0); e_en = 16'h0100;
    @(negedge clk); evt_pwrbtn = 1;
    @(negedge clk);
    io_addr = B; io_wdata = 32'h0100; io_wide = 0; io_wr = 1;
    @(negedge clk); io_wr = 0;
    #2 check("R7 clear wins", sci, 0);
    @(negedge clk);
    #2 check("R7 reset again", sci, 1);
    evt_pwrbtn = 0;
    bus_wr(B + 0, 32'hFFFF, 0); e_sts = 0;

    // R8 counter and wrap
    bus_wr(B + 2, 32'h0001, 0); e_en = 16'h0001;
    @(negedge clk); tmr_tick = 1;
    repeat (5) @(negedge clk);
    tmr_tick = 0;
    bus_rd(B + 8, 1, v); check("R8 count", v, 5);
    check("R8 no wrap sci", sci, 0);
    @(negedge clk); tmr_tick = 1;
    repeat ((1 << TW) - 5) @(negedge clk);
    tmr_tick = 0;
    bus_rd(B + 8, 1, v); check("R8 wrap value", v, 0);
    bus_rd(B + 0, 0, v); check("R8 wrap flag", v, 1);
    check("R9 timer sci", sci, 1);
    bus_wr(B + 0, 32'h0001, 0); e_sts = 0;
    bus_wr(B + 2, 32'h0, 0); e_en = 0;

    // random mix against model
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      logic [31:0] op;
      d = $urandom;
      op = $urandom % 4;
      case (op)
        0: begin bus_wr(B + 2, d, 0); e_en = d[15:0]; end
        1: begin bus_wr(B + 4, d, 0); e_cnt = d[15:0]; end
        2: begin pulse(d[0], d[1], d[2]); e_sts |= ev_bits(d[0], d[1], d[2]); end
        default: begin bus_wr(B + 0, d, 0); e_sts &= ~(d[15:0] & MASK); end
      endcase
      #2 check("R9 random sci", sci, exp_sci(e_sts, e_en));
      bus_rd(B + 0, 0, v); check("R6 random sts", v, {16'h0, e_sts});
      bus_rd(B + 4, 0, v); check("R4 random cnt", v, {16'h0, e_cnt});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule